// File: doc/BRIEF.md
# Serial EEPROM Configuration Preloader

After reset, this block copies a 64-byte configuration image out of a three-wire serial EEPROM. It places the few configurable header fields into registers that the rest of the device can only read. The load starts by itself when the power-on reset is released, and again each time the bus reset is released. While the load runs, a busy flag stays high, and the bus target answers every access with a retry. When the last word has been taken in, busy drops and the field values are frozen until the next reset.

The image is fetched as nine read commands. Each command sends a start bit, a read opcode and a 6-bit word address. The device then streams words back to back without a new command. Only five fields are kept: the subsystem vendor ID, the subsystem ID, the interrupt pin, the minimum grant and the maximum latency. Every other byte is clocked in and dropped. With no device fitted, the data-in line is pulled low and all five fields load as zero.

Top module: `ee_cfg_preload`

## Requirements
- R1: While `por` or `pci_rst` is high at a clock edge (synchronous, active-high), `busy` is 1, `sp_cs` and `sp_clk` are 0 and all five fields are zero. The load starts without any other input once both are low. `sp_cs` first rises exactly CLK_DIV clock cycles after the release.
- R2: A load consists of exactly nine read commands, issued in this order. Their start word addresses are 0, 4, 8, 12, 16, 20, 22, 24, 30 and they read 4, 4, 4, 4, 4, 2, 2, 6, 2 words. This covers words 0 to 31 (bytes 0 to 63) once each.
- R3: Within a command `sp_clk` has a period of CLK_DIV cycles, high for CLK_DIV/2. `sp_dout` presents bit 1, then opcode bits 1 and 0, then the 6-bit word address MSB first, one bit per `sp_clk` rising edge.
- R4: After the address, the block skips one dummy bit. It then shifts in 16 bits per word, MSB first, sampling `sp_din` at each falling edge of `sp_clk`. Consecutive words of one command follow with no gap. Word w carries byte 2w in bits [7:0] and byte 2w+1 in bits [15:8].
- R5: Field mapping: the subsystem vendor ID is word 22 (bytes 44-45) and the subsystem ID is word 23. The interrupt pin is byte 61, the minimum grant byte 62 and the maximum latency byte 63. No other byte, including bytes 0 to 43 and byte 60, affects any output.
- R6: Between commands `sp_cs` stays low for at least CLK_DIV cycles. `sp_clk` is never high while `sp_cs` is low.
- R7: With `sp_din` held low throughout, all five fields read zero and `busy` still falls at the end of the sequence.
- R8: Once `busy` has fallen, the fields, `sp_cs` and `sp_clk` stay unchanged whatever `sp_din` does, until the next reset.
- R9: Raising `pci_rst` in the middle of a load abandons it and clears the fields. The load then restarts from word address 0 with the full nine-command sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| por | input | 1 | Power-on reset, active high, synchronous |
| pci_rst | input | 1 | Bus reset, active high, synchronous |
| sp_din | input | 1 | Serial data from the EEPROM (pulled low when absent) |
| sp_cs | output | 1 | EEPROM chip select |
| sp_clk | output | 1 | EEPROM serial clock |
| sp_dout | output | 1 | Serial data to the EEPROM |
| busy | output | 1 | High while loading; the target retries accesses |
| cfg_subsys_vid | output | 16 | Loaded subsystem vendor ID |
| cfg_subsys_id | output | 16 | Loaded subsystem ID |
| cfg_max_latency | output | 8 | Loaded maximum latency |
| cfg_min_grant | output | 8 | Loaded minimum grant |
| cfg_int_pin | output | 8 | Loaded interrupt pin |

## Verification
The bench loads images whose placeholder words are all ones, next to images with varied content. A design that took a field from the wrong word, swapped the two bytes of a word or let a placeholder word through would show corrupted fields. An EEPROM model logs every command's address and word count. This exposes a wrong segment table, an off-by-one in the dummy-bit skip (which shifts every field by one bit) and too short a chip-select gap. A bus reset applied after the ID words have already loaded checks that a design which kept stale fields, or resumed from the middle of the image, is caught. Toggling the data line after completion catches fields that are not frozen.

// File: rtl/ee_preload_pkg.sv
package ee_preload_pkg;

    localparam int IMG_BYTES = 64;
    localparam int IMG_WORDS = IMG_BYTES / 2;
    localparam int ADDR_W    = 6;
    localparam int WIDX_W    = $clog2(IMG_WORDS);
    localparam int N_XFER    = 9;
    localparam int XFER_W    = $clog2(N_XFER + 1);
    localparam int SLOT_W    = 8;
    localparam int HDR_SLOTS = 3 + ADDR_W;   // start, two opcode bits, address

    // word positions of the kept fields
    localparam int W_SVID   = 22;
    localparam int W_SID    = 23;
    localparam int W_PIN    = 30;
    localparam int W_GNTLAT = 31;

    typedef enum logic [1:0] {
        SEQ_GAP,
        SEQ_XFER,
        SEQ_DONE
    } seq_state_e;

    typedef struct packed {
        logic [15:0] svid;
        logic [15:0] sid;
        logic [7:0]  max_lat;
        logic [7:0]  min_gnt;
        logic [7:0]  int_pin;
    } cfg_fields_t;

    function automatic logic [ADDR_W-1:0] xfer_first(input logic [XFER_W-1:0] k);
        case (k)
            4'd0:    return 6'd0;
            4'd1:    return 6'd4;
            4'd2:    return 6'd8;
            4'd3:    return 6'd12;
            4'd4:    return 6'd16;
            4'd5:    return 6'd20;
            4'd6:    return 6'd22;
            4'd7:    return 6'd24;
            4'd8:    return 6'd30;
            default: return 6'd0;
        endcase
    endfunction

    function automatic logic [2:0] xfer_words(input logic [XFER_W-1:0] k);
        case (k)
            4'd5, 4'd6, 4'd8: return 3'd2;
            4'd7:             return 3'd6;
            default:          return 3'd4;
        endcase
    endfunction

    // command bit for a header slot: 1, 1, 0, then address MSB first
    function automatic logic cmd_bit(input logic [SLOT_W-1:0] s,
                                     input logic [ADDR_W-1:0] a);
        logic [SLOT_W-1:0] idx;
        idx = SLOT_W'(HDR_SLOTS - 1) - s;
        if (s < SLOT_W'(2))              return 1'b1;
        else if (s == SLOT_W'(2))        return 1'b0;
        else if (s < SLOT_W'(HDR_SLOTS)) return a[idx[2:0]];
        else                             return 1'b0;
    endfunction

endpackage

// File: rtl/ee_sk_div.sv
module ee_sk_div #(
    parameter int CLK_DIV = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    localparam int HALF  = CLK_DIV / 2;
    localparam int CNT_W = $clog2(HALF) + 1;

    logic [CNT_W-1:0] cnt;

    assign tick = run && (cnt == CNT_W'(HALF - 1));

    always_ff @(posedge clk) begin
        if (rst || !run || tick) cnt <= '0;
        else                     cnt <= cnt + CNT_W'(1);
    end

    generate
        if (HALF > 1) begin : g_spacing
            p_tick_spacing_r3 : assert property (@(posedge clk) disable iff (rst)
                tick |=> !tick);
        end
    endgenerate
endmodule

// File: rtl/ee_rd_seq.sv
module ee_rd_seq
    import ee_preload_pkg::*;
#(
    parameter int CLK_DIV = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              din,
    output logic              cs,
    output logic              sk,
    output logic              dout,
    output logic              busy,
    output logic              wr,
    output logic [WIDX_W-1:0] widx,
    output logic [15:0]       wdata
);
    seq_state_e        state;
    logic [XFER_W-1:0] seg;
    logic [SLOT_W-1:0] slot;
    logic              gap_half;
    logic [14:0]       sh;

    logic [ADDR_W-1:0] seg_addr;
    logic [SLOT_W-1:0] last_slot;
    logic [SLOT_W-1:0] dpos;

    assign seg_addr  = xfer_first(seg);
    assign last_slot = SLOT_W'(HDR_SLOTS - 1) + {1'b0, xfer_words(seg), 4'b0000};
    assign dpos      = slot - SLOT_W'(HDR_SLOTS);
    assign busy      = (state != SEQ_DONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= SEQ_GAP;
            seg      <= '0;
            slot     <= '0;
            gap_half <= 1'b0;
            cs       <= 1'b0;
            sk       <= 1'b0;
            dout     <= 1'b0;
            sh       <= '0;
            wr       <= 1'b0;
            widx     <= '0;
            wdata    <= '0;
        end else begin
            wr <= 1'b0;
            case (state)
                SEQ_GAP: begin
                    if (seg == XFER_W'(N_XFER)) begin
                        state <= SEQ_DONE;
                    end else if (tick) begin
                        if (gap_half) begin
                            cs       <= 1'b1;
                            dout     <= cmd_bit('0, seg_addr);
                            slot     <= '0;
                            gap_half <= 1'b0;
                            state    <= SEQ_XFER;
                        end else begin
                            gap_half <= 1'b1;
                        end
                    end
                end
                SEQ_XFER: begin
                    if (tick) begin
                        if (!sk) begin
                            sk <= 1'b1;
                        end else begin
                            sk <= 1'b0;
                            if (slot >= SLOT_W'(HDR_SLOTS)) begin
                                sh <= {sh[13:0], din};
                                if (dpos[3:0] == 4'hF) begin
                                    wr    <= 1'b1;
                                    widx  <= seg_addr[WIDX_W-1:0] + {1'b0, dpos[7:4]};
                                    wdata <= {sh, din};
                                end
                            end
                            if (slot == last_slot) begin
                                cs    <= 1'b0;
                                dout  <= 1'b0;
                                seg   <= seg + XFER_W'(1);
                                state <= SEQ_GAP;
                            end else begin
                                slot <= slot + SLOT_W'(1);
                                dout <= cmd_bit(slot + SLOT_W'(1), seg_addr);
                            end
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // chip-select low-time monitor for the gap check
    localparam int LOW_W = $clog2(CLK_DIV + 1);
    logic [LOW_W-1:0] low_cnt;
    always_ff @(posedge clk) begin
        if (rst)                          low_cnt <= '0;
        else if (cs)                      low_cnt <= '0;
        else if (low_cnt != LOW_W'(CLK_DIV)) low_cnt <= low_cnt + LOW_W'(1);
    end

    p_start_bit_r3 : assert property (@(posedge clk) disable iff (rst)
        $rose(cs) |-> dout);
    p_sk_idle_r6 : assert property (@(posedge clk) disable iff (rst)
        !cs |-> !sk);
    p_gap_len_r6 : assert property (@(posedge clk) disable iff (rst)
        $rose(cs) |-> (low_cnt >= LOW_W'(CLK_DIV)));
endmodule

// File: rtl/ee_field_latch.sv
module ee_field_latch
    import ee_preload_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [WIDX_W-1:0] widx,
    input  logic [15:0]       wdata,
    output cfg_fields_t       fields
);
    always_ff @(posedge clk) begin
        if (rst) begin
            fields <= '0;
        end else if (wr) begin
            case (widx)
                WIDX_W'(W_SVID):   fields.svid    <= wdata;
                WIDX_W'(W_SID):    fields.sid     <= wdata;
                WIDX_W'(W_PIN):    fields.int_pin <= wdata[15:8];
                WIDX_W'(W_GNTLAT): begin
                    fields.min_gnt <= wdata[7:0];
                    fields.max_lat <= wdata[15:8];
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/ee_cfg_preload.sv
module ee_cfg_preload
    import ee_preload_pkg::*;
#(
    parameter int CLK_DIV = 64
) (
    input  logic        clk,
    input  logic        por,
    input  logic        pci_rst,
    input  logic        sp_din,
    output logic        sp_cs,
    output logic        sp_clk,
    output logic        sp_dout,
    output logic        busy,
    output logic [15:0] cfg_subsys_vid,
    output logic [15:0] cfg_subsys_id,
    output logic [7:0]  cfg_max_latency,
    output logic [7:0]  cfg_min_grant,
    output logic [7:0]  cfg_int_pin
);
    logic              rst_any;
    logic              tick;
    logic              wr;
    logic [WIDX_W-1:0] widx;
    logic [15:0]       wdata;
    cfg_fields_t       fields;

    assign rst_any = por | pci_rst;

    ee_sk_div #(.CLK_DIV(CLK_DIV)) u_div (
        .clk (clk),
        .rst (rst_any),
        .run (busy),
        .tick(tick)
    );

    ee_rd_seq #(.CLK_DIV(CLK_DIV)) u_seq (
        .clk  (clk),
        .rst  (rst_any),
        .tick (tick),
        .din  (sp_din),
        .cs   (sp_cs),
        .sk   (sp_clk),
        .dout (sp_dout),
        .busy (busy),
        .wr   (wr),
        .widx (widx),
        .wdata(wdata)
    );

    ee_field_latch u_latch (
        .clk   (clk),
        .rst   (rst_any),
        .wr    (wr),
        .widx  (widx),
        .wdata (wdata),
        .fields(fields)
    );

    assign cfg_subsys_vid  = fields.svid;
    assign cfg_subsys_id   = fields.sid;
    assign cfg_max_latency = fields.max_lat;
    assign cfg_min_grant   = fields.min_gnt;
    assign cfg_int_pin     = fields.int_pin;

    p_reset_state_r1 : assert property (@(posedge clk)
        rst_any |=> (busy && !sp_cs && !sp_clk && fields == '0));
    p_fields_locked_r8 : assert property (@(posedge clk) disable iff (rst_any)
        (!busy && !$past(busy)) |-> $stable(fields));
endmodule

// File: tb/ee_cfg_preload_test.sv
`timescale 1ns/1ps
module ee_cfg_preload_test;
    localparam int CLK_DIV = 16;

    logic clk = 1'b0;
    logic por = 1'b1;
    logic pci_rst = 1'b0;
    logic sp_din;
    logic sp_cs, sp_clk, sp_dout, busy;
    logic [15:0] vid, sid;
    logic [7:0]  mlat, mgnt, ipin;

    always #2 clk = ~clk;

    ee_cfg_preload #(.CLK_DIV(CLK_DIV)) uut (
        .clk(clk), .por(por), .pci_rst(pci_rst), .sp_din(sp_din),
        .sp_cs(sp_cs), .sp_clk(sp_clk), .sp_dout(sp_dout), .busy(busy),
        .cfg_subsys_vid(vid), .cfg_subsys_id(sid), .cfg_max_latency(mlat),
        .cfg_min_grant(mgnt), .cfg_int_pin(ipin)
    );

    int total = 0;
    int bad = 0;

    task automatic check(input logic ok, input string tag, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    // ---------------- EEPROM model ----------------
    logic [15:0] mem [32];
    logic present = 1'b1;
    logic do_r = 1'b0;
    logic force_en = 1'b0, force_val = 1'b0;
    int rise_n = 0;
    logic [2:0] cmd_sh;
    logic [5:0] adr_sh;
    int tr_count = 0;
    int tr_addr [10];
    int tr_words [10];
    int proto_err = 0;
    int mk, mw;

    assign sp_din = force_en ? force_val : do_r;

    always @(negedge sp_cs) begin
        rise_n = 0;
        do_r   = 1'b0;
        cmd_sh = 3'b000;
    end

    always @(posedge sp_clk) begin
        if (sp_cs) begin
            rise_n++;
            if (rise_n <= 3) cmd_sh = {cmd_sh[1:0], sp_dout};
            else if (rise_n <= 9) adr_sh = {adr_sh[4:0], sp_dout};
            if (rise_n == 3 && cmd_sh != 3'b110) proto_err++;
            if (rise_n == 9) begin
                if (tr_count < 10) begin
                    tr_addr[tr_count]  = int'(adr_sh);
                    tr_words[tr_count] = 0;
                end
                tr_count++;
                do_r = 1'b0;
            end else if (rise_n >= 10) begin
                mk = rise_n - 10;
                mw = (int'(adr_sh) + mk / 16) % 32;
                if (tr_count >= 1 && tr_count <= 10) tr_words[tr_count-1] = mk / 16 + 1;
                do_r = present ? mem[mw][15 - mk % 16] : 1'b0;
            end
        end
    end

    // ---------------- pin timing monitor ----------------
    int cyc = 0;
    logic cs_q = 1'b0, sk_q = 1'b0;
    int low_run = 0;
    int gap_err = 0;
    int sk_err = 0;
    int first_rise = -1;
    int last_rise = 0;
    logic rise_ok = 1'b0;

    always @(posedge clk) begin
        cyc  <= cyc + 1;
        cs_q <= sp_cs;
        sk_q <= sp_clk;
        if (sp_cs === 1'b0) low_run <= low_run + 1; else low_run <= 0;
        if (sp_cs === 1'b1 && !cs_q) begin
            if (low_run < CLK_DIV) gap_err <= gap_err + 1;
            if (first_rise < 0) first_rise <= cyc;
        end
        if (sp_cs === 1'b0 && sp_clk === 1'b1) sk_err <= sk_err + 1;
        if (sp_cs === 1'b1 && sp_clk === 1'b1 && !sk_q) begin
            if (rise_ok && (cyc - last_rise) != CLK_DIV) sk_err <= sk_err + 1;
            last_rise <= cyc;
            rise_ok   <= 1'b1;
        end
        if (sp_cs === 1'b1 && sp_clk === 1'b0 && sk_q && (cyc - last_rise) != CLK_DIV / 2)
            sk_err <= sk_err + 1;
        if (sp_cs !== 1'b1) rise_ok <= 1'b0;
    end

    // ---------------- helpers ----------------
    function automatic int exp_first(input int k);
        int t [9] = '{0, 4, 8, 12, 16, 20, 22, 24, 30};
        return t[k];
    endfunction
    function automatic int exp_len(input int k);
        int t [9] = '{4, 4, 4, 4, 4, 2, 2, 6, 2};
        return t[k];
    endfunction

    task automatic fill(input int seed, input logic ones_placeholders);
        for (int w = 0; w < 32; w++) begin
            mem[w] = 16'((w + 1) * (seed * 16'h3B1 + 16'h11) ^ (seed << 7) ^ 16'h9E37);
            if (ones_placeholders && !(w == 22 || w == 23 || w == 30 || w == 31)) mem[w] = 16'hFFFF;
        end
    endtask

    task automatic clear_logs();
        tr_count = 0; proto_err = 0;
        gap_err = 0; sk_err = 0; first_rise = -1;
    endtask

    task automatic wait_done(input string tag);
        int n = 0;
        while (busy !== 1'b0 && n < 40000) begin @(negedge clk); n++; end
        check(busy === 1'b0, {tag, " busy never fell"}, busy, 0);
        repeat (2) @(negedge clk);
    endtask

    task automatic check_sequence(input string tag);
        check(tr_count == 9, {"R2 command count ", tag}, tr_count, 9);
        for (int k = 0; k < 9; k++) begin
            check(tr_addr[k] == exp_first(k), {"R2 start address ", tag}, tr_addr[k], exp_first(k));
            check(tr_words[k] == exp_len(k), {"R2 word count ", tag}, tr_words[k], exp_len(k));
        end
        check(proto_err == 0, {"R3 opcode/start bits ", tag}, proto_err, 0);
        check(sk_err == 0, {"R3 serial clock timing ", tag}, sk_err, 0);
        check(gap_err == 0, {"R6 select gap ", tag}, gap_err, 0);
    endtask

    task automatic check_fields(input string tag, input logic zero);
        logic [15:0] ev, es;
        logic [7:0] el, eg, ep;
        ev = zero ? 16'h0 : mem[22];
        es = zero ? 16'h0 : mem[23];
        ep = zero ? 8'h0 : mem[30][15:8];
        eg = zero ? 8'h0 : mem[31][7:0];
        el = zero ? 8'h0 : mem[31][15:8];
        check(vid == ev,  {"R5 subsystem vendor id ", tag}, vid, ev);
        check(sid == es,  {"R5 subsystem id ", tag}, sid, es);
        check(ipin == ep, {"R4 interrupt pin byte61 ", tag}, ipin, ep);
        check(mgnt == eg, {"R4 min grant byte62 ", tag}, mgnt, eg);
        check(mlat == el, {"R4 max latency byte63 ", tag}, mlat, el);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset_state();
        por = 1'b1;
        repeat (3) @(negedge clk);
        check(busy === 1'b1, "R1 busy in reset", busy, 1);
        check(sp_cs === 1'b0, "R1 cs in reset", sp_cs, 0);
        check(sp_clk === 1'b0, "R1 sk in reset", sp_clk, 0);
        check({vid, sid, mlat, mgnt, ipin} == '0, "R1 fields in reset", vid, 0);
    endtask

    task automatic t_load(input string tag, input int seed, input logic ones, input logic fitted);
        int rel;
        fill(seed, ones);
        present = fitted;
        por = 1'b1;
        @(negedge clk);
        clear_logs();
        rel = cyc;
        por = 1'b0;
        wait_done(tag);
        check(first_rise - rel == CLK_DIV, {"R1 first select delay ", tag}, first_rise - rel, CLK_DIV);
        check_sequence(tag);
        check_fields(tag, !fitted);
        if (!fitted) check(busy === 1'b0, "R7 busy falls without device", busy, 0);
    endtask

    task automatic t_hold();
        logic [55:0] snap;
        snap = {vid, sid, mlat, mgnt, ipin};
        force_en = 1'b1;
        for (int i = 0; i < 300; i++) begin
            force_val = i[0] ^ i[3];
            @(negedge clk);
            if (sp_cs !== 1'b0 || sp_clk !== 1'b0)
                check(1'b0, "R8 pins active after load", {sp_cs, sp_clk}, 0);
        end
        force_en = 1'b0;
        check({vid, sid, mlat, mgnt, ipin} == snap, "R8 fields frozen", {vid, sid, mlat, mgnt, ipin}, snap);
        check(busy === 1'b0, "R8 busy stays low", busy, 0);
    endtask

    task automatic t_abort();
        int n = 0;
        fill(9, 1'b0);
        present = 1'b1;
        por = 1'b1;
        @(negedge clk);
        clear_logs();
        por = 1'b0;
        while (tr_count < 8 && n < 40000) begin @(negedge clk); n++; end
        check(vid == mem[22], "R9 partial load reached ids", vid, mem[22]);
        pci_rst = 1'b1;
        repeat (2) @(negedge clk);
        check(busy === 1'b1, "R9 busy during bus reset", busy, 1);
        check({vid, sid, mlat, mgnt, ipin} == '0, "R9 fields cleared by bus reset", vid, 0);
        clear_logs();
        pci_rst = 1'b0;
        wait_done("restart");
        check(tr_addr[0] == 0, "R9 restart from address 0", tr_addr[0], 0);
        check_sequence("restart");
        check_fields("restart", 1'b0);
    endtask

    logic finished = 1'b0;

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL R1 watchdog expired act=%0d exp=done", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        t_reset_state();
        t_load("varied image", 1, 1'b0, 1'b1);
        t_hold();
        t_load("ones placeholders", 5, 1'b1, 1'b1);
        t_load("no device", 3, 1'b0, 1'b0);
        t_abort();
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule